// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the contents of a dynamic memory alive by issuing refresh cycles in which only the row strobe is taken low and the column strobe never leaves its high level. An interval timer, loaded from a port and counted in clock cycles, decides when refresh work is due. An internal row counter supplies the row for each refresh and steps through all rows in turn. The default of 1024 rows is chosen so that every row is visited inside the 16 ms retention window.

The block shares the memory pins with an access controller. When refresh work is waiting it raises a request. It drives the strobes and the row address only after the controller has granted the bus. It hands the bus back one cycle after the cycle's precharge ends.

Two schedules are offered. In the spread schedule, each timer expiry queues one row; about 15.6 µs between expiries covers all rows in time. In the block schedule, one expiry per retention period queues every row, and the rows are then refreshed back to back. Expiries that arrive while the controller holds the bus are kept in a small backlog. A sticky flag records any expiry that could not be kept.

Top module: `dram_ref_sched`

## Requirements
- R1: While reset is low, and right after it is released, ras_n and cas_n are 1, ref_req and bus_en are 0, row_addr is 0 and sched_ovf is 0.
- R2: With a non-zero interval I, the timer expires every I cycles. With prompt grants in spread mode, consecutive ras_n falling edges are exactly I cycles apart. An interval of 0 stops the timer, so no request is raised.
- R3: ref_req rises only while refresh work is waiting. bus_en and a low ras_n occur only while ref_gnt is high. ref_req and bus_en fall in the same cycle, one cycle after the precharge ends.
- R4: Each refresh keeps ras_n low for exactly ACT_CYC cycles (3 by default). row_addr is stable during that time, and cas_n stays 1 at all times.
- R5: Between two refreshes, ras_n stays high for at least PRE_CYC cycles (2 by default).
- R6: The first refresh after reset uses row 0. Each later refresh uses the next row, and row ROWS-1 (1023) is followed by row 0.
- R7: In spread mode, expiries that arrive while the grant is withheld are queued, up to PEND_MAX (4 by default). Each queued expiry is served by one refresh once the grant is given.
- R8: sched_ovf becomes 1 when an expiry arrives in spread mode with PEND_MAX expiries already queued, or in block mode while rows of the previous block are still owed. It stays 1 until reset.
- R9: In block mode (burst_mode = 1), an expiry queues all ROWS refreshes. When the grant returns in the cycle after each request, the refreshes follow each other with ras_n falling edges ACT_CYC+PRE_CYC+3 cycles apart (8 by default).
- R10: Whenever bus_en is 0, ras_n is 1 and row_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 0: one row per expiry, 1: all rows per expiry |
| interval | input | ITV_W | Timer period in cycles, 0 stops the timer |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request to the access controller |
| bus_en | output | 1 | High while this block drives strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, held high |
| row_addr | output | ROW_W | Row being refreshed, 0 while not driving |
| sched_ovf | output | 1 | Sticky backlog overflow flag |

## Verification
Several properties are checked on every cycle by the assertions: the row strobe never falls without a grant, the row stays put while the strobe is low, the row counter moves only when a cycle completes, and the bus is released as the request drops. The overflow flag is also checked to never clear outside reset. The bench scenarios are the only evidence for the behaviour that depends on counting: the exact expiry spacing, how many queued refreshes survive a withheld grant, the overflow threshold, the length of a full block, and the wrap of the row counter from the last row to row 0.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
   typedef enum logic [2:0] {
      RS_IDLE,
      RS_REQ,
      RS_ACT,
      RS_PRE,
      RS_REL
   } ref_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int ITV_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ITV_W-1:0] interval,
   output logic             tick
);
   logic [ITV_W-1:0] cnt;

   assign tick = (interval != '0) && (cnt >= interval - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt <= '0;
      else if (interval == '0 || tick)   cnt <= '0;
      else                               cnt <= cnt + 1'b1;
   end

   // R2: with a steady period above one, two expiries are never adjacent
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && interval > 1) |=> (!tick || interval != $past(interval)));
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
   parameter int ROWS     = 1024,
   parameter int PEND_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic burst_mode,
   input  logic tick,
   input  logic done,
   output logic pend_nz,
   output logic ovf
);
   localparam int CNT_W = $clog2(ROWS + 1);
   localparam logic [CNT_W-1:0] ALL_ROWS = CNT_W'(ROWS);
   localparam logic [CNT_W-1:0] CAP      = CNT_W'(PEND_MAX);

   logic [CNT_W-1:0] pend;
   logic [CNT_W-1:0] base;

   always_comb base = pend - {{(CNT_W-1){1'b0}}, done};

   assign pend_nz = (pend != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         ovf  <= 1'b0;
      end else if (!tick) begin
         pend <= base;
      end else if (burst_mode) begin
         if (base != '0) begin
            ovf  <= 1'b1;
            pend <= base;
         end else begin
            pend <= ALL_ROWS;
         end
      end else begin
         if (base >= CAP) begin
            ovf  <= 1'b1;
            pend <= base;
         end else begin
            pend <= base + 1'b1;
         end
      end
   end

   p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   p_done_has_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend != '0);
   p_backlog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= ALL_ROWS);
endmodule

// File: rtl/ref_cycle_fsm.sv
module ref_cycle_fsm
   import dram_ref_pkg::*;
#(
   parameter int ROWS    = 1024,
   parameter int ROW_W   = 10,
   parameter int ACT_CYC = 3,
   parameter int PRE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             work,
   input  logic             gnt,
   output logic             req,
   output logic             bus_en,
   output logic             ras_n,
   output logic [ROW_W-1:0] row,
   output logic             done
);
   localparam int TMAX = (ACT_CYC > PRE_CYC) ? ACT_CYC : PRE_CYC;
   localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
   localparam logic [TW-1:0] ACT_LAST = TW'(ACT_CYC - 1);
   localparam logic [TW-1:0] PRE_LAST = TW'(PRE_CYC - 1);

   ref_state_e       st;
   logic [TW-1:0]    tcnt;
   logic [ROW_W-1:0] row_nxt;

   generate
      if (ROWS == (1 << ROW_W)) begin : g_pow2_wrap
         always_comb row_nxt = row + 1'b1;
      end else begin : g_cmp_wrap
         always_comb row_nxt = (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
      end
   endgenerate

   assign done   = (st == RS_PRE) && (tcnt == PRE_LAST);
   assign req    = (st == RS_REQ) || (st == RS_ACT) || (st == RS_PRE);
   assign bus_en = (st == RS_ACT) || (st == RS_PRE);
   assign ras_n  = (st != RS_ACT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= RS_IDLE;
         tcnt <= '0;
         row  <= '0;
      end else begin
         case (st)
            RS_IDLE: if (work && !gnt) st <= RS_REQ;
            RS_REQ: if (gnt) begin
               st   <= RS_ACT;
               tcnt <= '0;
            end
            RS_ACT: if (tcnt == ACT_LAST) begin
               st   <= RS_PRE;
               tcnt <= '0;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
            RS_PRE: if (done) begin
               st  <= RS_REL;
               row <= row_nxt;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
            RS_REL:  st <= RS_IDLE;
            default: st <= RS_IDLE;
         endcase
      end
   end

   p_ras_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> gnt);
   p_release_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> !bus_en);
   p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $past(!ras_n)) |-> $stable(row));
   p_row_moves_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row) |-> $past(done));
   p_precharge_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> ras_n);
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
   parameter int ROWS     = 1024,
   parameter int ROW_W    = $clog2(ROWS),
   parameter int ITV_W    = 20,
   parameter int ACT_CYC  = 3,
   parameter int PRE_CYC  = 2,
   parameter int PEND_MAX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             burst_mode,
   input  logic [ITV_W-1:0] interval,
   input  logic             ref_gnt,
   output logic             ref_req,
   output logic             bus_en,
   output logic             ras_n,
   output logic             cas_n,
   output logic [ROW_W-1:0] row_addr,
   output logic             sched_ovf
);
   generate
      if (ACT_CYC < 1 || PRE_CYC < 1 || ROWS < 2 || PEND_MAX < 1 ||
          PEND_MAX > ROWS || (1 << ROW_W) < ROWS || ITV_W < 2) begin : g_bad_cfg
         $error("dram_ref_sched: parameter set out of range");
      end
   endgenerate

   logic             tick;
   logic             work;
   logic             done;
   logic             en_i;
   logic             ras_i;
   logic [ROW_W-1:0] row_i;

   ref_interval_timer #(.ITV_W(ITV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .interval(interval), .tick(tick)
   );

   ref_backlog #(.ROWS(ROWS), .PEND_MAX(PEND_MAX)) u_backlog (
      .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .tick(tick),
      .done(done), .pend_nz(work), .ovf(sched_ovf)
   );

   ref_cycle_fsm #(.ROWS(ROWS), .ROW_W(ROW_W), .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .work(work), .gnt(ref_gnt), .req(ref_req),
      .bus_en(en_i), .ras_n(ras_i), .row(row_i), .done(done)
   );

   assign bus_en   = en_i;
   assign ras_n    = en_i ? ras_i : 1'b1;
   assign row_addr = en_i ? row_i : '0;
   assign cas_n    = 1'b1;

   p_idle_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> (ras_n && row_addr == '0));
   p_req_needs_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_req) |-> $past(work));
endmodule

// File: tb/dram_ref_sched_bench.sv
`timescale 1ns/1ps
module dram_ref_sched_bench;
   localparam int ROWS = 1024;
   localparam int ACT_CYC = 3;
   localparam int PRE_CYC = 2;
   localparam int PEND_MAX = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        burst_mode = 1'b0;
   logic [19:0] interval = '0;
   logic        ref_gnt = 1'b0;
   logic        ref_req, bus_en, ras_n, cas_n, sched_ovf;
   logic [9:0]  row_addr;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int lat = 0;
   bit gnt_block = 1'b0;
   int wait_cnt = 0;
   int nref = 0, exp_row = 0, last_row = 0, low_w = 0, high_w = 0, last_fall = 0;
   bit first = 1'b1, ras_prev = 1'b1, req_prev = 1'b0;
   int space_exp = 0;
   string space_tag = "R2";
   int cas_err = 0, gnt_err = 0, idle_err = 0, rel_err = 0, hold_err = 0;

   // interval, grant latency, expiries while blocked, expected refreshes, expected overflow
   localparam int NVEC = 5;
   localparam int VEC [NVEC][5] = '{
      '{20, 1, 2, 2, 0},
      '{20, 3, 4, 4, 0},
      '{20, 2, 6, 4, 1},
      '{16, 0, 5, 4, 1},
      '{30, 0, 1, 1, 0}
   };

   dram_ref_sched u_dram_ref_sched (
      .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .interval(interval),
      .ref_gnt(ref_gnt), .ref_req(ref_req), .bus_en(bus_en), .ras_n(ras_n),
      .cas_n(cas_n), .row_addr(row_addr), .sched_ovf(sched_ovf)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic do_reset(input int itv, input bit bm);
      rst_n = 1'b0;
      interval = 20'(itv);
      burst_mode = bm;
      repeat (3) @(negedge clk);
      check(ras_n === 1'b1 && cas_n === 1'b1, "R1 strobes in reset", {ras_n, cas_n}, 3);
      check(ref_req === 1'b0 && bus_en === 1'b0, "R1 req/bus in reset", {ref_req, bus_en}, 0);
      check(row_addr === '0 && sched_ovf === 1'b0, "R1 row/ovf in reset", int'(row_addr), 0);
      rst_n = 1'b1;
   endtask

   // grant responder
   always @(negedge clk) begin
      if (!rst_n || !ref_req) begin
         ref_gnt = 1'b0;
         wait_cnt = 0;
      end else if (!ref_gnt && !gnt_block) begin
         if (wait_cnt >= lat) ref_gnt = 1'b1;
         else wait_cnt++;
      end
   end

   // bus monitor
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         nref = 0; exp_row = 0; low_w = 0; high_w = 0;
         first = 1'b1; ras_prev = 1'b1; req_prev = 1'b0;
      end else begin
         if (cas_n !== 1'b1) cas_err++;
         if (bus_en && !ref_gnt) gnt_err++;
         if (!bus_en && (ras_n !== 1'b1 || row_addr != '0)) idle_err++;
         if (req_prev && !ref_req && bus_en) rel_err++;
         if (!req_prev && ref_req && bus_en) rel_err++;
         if (!ras_n && ras_prev) begin
            check(int'(row_addr) == exp_row, "R6 row order", int'(row_addr), exp_row);
            if (!first) begin
               check(high_w >= PRE_CYC, "R5 precharge gap", high_w, PRE_CYC);
               if (space_exp != 0)
                  check(cyc - last_fall == space_exp, space_tag, cyc - last_fall, space_exp);
            end
            last_row = int'(row_addr);
            exp_row = (exp_row + 1) % ROWS;
            first = 1'b0;
            last_fall = cyc;
            nref++;
            low_w = 1;
         end else if (!ras_n) begin
            low_w++;
            if (int'(row_addr) != last_row) hold_err++;
         end else if (!ras_prev) begin
            check(low_w == ACT_CYC, "R4 strobe low width", low_w, ACT_CYC);
            high_w = 1;
         end else begin
            high_w++;
         end
         ras_prev = ras_n;
         req_prev = ref_req;
      end
   end

   // watchdog
   always @(negedge clk) begin
      if (cyc > 180000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 / R2: stopped timer raises nothing
      do_reset(0, 1'b0);
      @(negedge clk);
      check(ras_n === 1'b1 && ref_req === 1'b0 && bus_en === 1'b0, "R1 after release",
            {ras_n, ref_req, bus_en}, 4);
      repeat (200) @(negedge clk);
      check(nref == 0 && ref_req == 1'b0, "R2 zero interval halts", nref, 0);

      // table walk: R7 backlog and R8 overflow in spread mode
      for (int i = 0; i < NVEC; i++) begin
         gnt_block = 1'b1;
         lat = VEC[i][1];
         do_reset(VEC[i][0], 1'b0);
         repeat (VEC[i][2] * VEC[i][0] + VEC[i][0] / 2) @(negedge clk);
         interval = '0;
         check(ref_req === 1'b1 && bus_en === 1'b0 && ras_n === 1'b1, "R3 waits for grant",
               {ref_req, bus_en, ras_n}, 5);
         check(sched_ovf == 1'(VEC[i][4]), "R8 overflow flag", int'(sched_ovf), VEC[i][4]);
         gnt_block = 1'b0;
         repeat (120) @(negedge clk);
         check(nref == VEC[i][3], "R7 queued refreshes served", nref, VEC[i][3]);
         check(ref_req === 1'b0 && bus_en === 1'b0, "R3 bus released", {ref_req, bus_en}, 0);
         check(sched_ovf == 1'(VEC[i][4]), "R8 flag sticky", int'(sched_ovf), VEC[i][4]);
      end

      // R2: steady spacing equals the interval
      gnt_block = 1'b0;
      lat = 1;
      space_tag = "R2 expiry spacing";
      space_exp = 40;
      do_reset(40, 1'b0);
      while (nref < 6) @(negedge clk);
      space_exp = 0;
      check(sched_ovf == 1'b0, "R8 no overflow when served", int'(sched_ovf), 0);

      // R9 block mode and R6 wrap
      lat = 0;
      space_tag = "R9 back-to-back spacing";
      space_exp = ACT_CYC + PRE_CYC + 3;
      do_reset(12000, 1'b1);
      while (nref < 1) @(negedge clk);
      repeat (1024 * 8 + 40) @(negedge clk);
      check(nref == ROWS, "R9 full block count", nref, ROWS);
      check(last_row == ROWS - 1, "R6 last row of block", last_row, ROWS - 1);
      space_exp = 0;
      while (nref < ROWS + 1) @(negedge clk);
      check(last_row == 0, "R6 wrap to row 0", last_row, 0);
      check(sched_ovf == 1'b0, "R8 block finished in time", int'(sched_ovf), 0);

      // R8: new block while previous one is still owed
      do_reset(3000, 1'b1);
      repeat (6100) @(negedge clk);
      check(sched_ovf == 1'b1, "R8 block overrun", int'(sched_ovf), 1);

      check(cas_err == 0, "R4 column strobe high", cas_err, 0);
      check(hold_err == 0, "R4 row stable while low", hold_err, 0);
      check(gnt_err == 0, "R3 drive only with grant", gnt_err, 0);
      check(rel_err == 0, "R3 release with request", rel_err, 0);
      check(idle_err == 0, "R10 quiet bus when not driving", idle_err, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule